// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block translates 32-bit virtual addresses to physical addresses through a 64-entry, fully associative buffer. Every entry is compared with the request in the same cycle. Each entry carries a 6-bit address-space tag, so mappings that belong to different processes can sit side by side. A context switch therefore only changes the tag presented with the request and never empties the buffer. The lookup is combinational: the result appears in the same cycle as the request.

Two fixed address windows skip the buffer and map straight onto the low physical space. One of them is cached and the other is not. Every other address must hit a live entry. A miss, a non-live match, or a store to an entry that forbids writing raises a fault. An outside refill agent handles the fault: it loads an entry through an indexed write port, and it can take the slot number from a free-running index counter. The agent can also kill a single slot, or clear every slot in one cycle.

Top module: `xlate_tlb`

## Requirements
- R1: While reset is held, `randIndex` reads 0. After reset, every slot is empty, so every lookup in a translated window raises `respFault`.
- R2: A load hits when a live slot holds the page number `reqVaddr[31:12]` and either its tag equals `curAsid` or its global bit is set. A hit gives `respHit`=1, `respPaddr` = {slot frame number, `reqVaddr[11:0]`}, and `respUncached` equal to the slot's no-cache bit.
- R3: A live slot whose page matches but whose tag differs from `curAsid`, with its global bit clear, does not hit, and the lookup faults.
- R4: When `reqVaddr[31:29]` is 100 or 101, the buffer is bypassed. The result is `respPaddr` = {3'b000, `reqVaddr[28:0]`}, with `respHit`=0, `respFault`=0 and `respModFault`=0. `respUncached` is 0 for 100 and 1 for 101.
- R5: Values 0xx and 11x of `reqVaddr[31:29]` are translated. If no live slot matches, the block gives `respFault`=1, `respHit`=0 and `respPaddr`=0. A slot written with its live bit clear never matches.
- R6: A store that matches a live slot whose writable bit is clear gives `respModFault`=1, `respHit`=0 and `respFault`=0. A load to the same slot hits.
- R7: A cycle with `wrEn` high loads all fields of slot `wrIndex`, replacing whatever that slot held before.
- R8: A cycle with `invOne` high clears the live bit of slot `invIndex`. If the write port names the same slot in the same cycle, the invalidate wins. A write to a different slot in that cycle still takes effect.
- R9: A cycle with `flushAll` high clears the live bit of every slot.
- R10: `randIndex` steps by one on every clock edge and wraps from 63 to 0.
- R11: While `reqValid` is low, `respHit`, `respFault`, `respModFault` and `respUncached` are 0, and `respPaddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A lookup is presented |
| reqVaddr | input | 32 | Virtual address |
| reqStore | input | 1 | 1 = store, 0 = load |
| curAsid | input | 6 | Address-space tag of the running process |
| respPaddr | output | 32 | Physical address |
| respHit | output | 1 | Translation succeeded through the buffer |
| respFault | output | 1 | Miss or non-live match; refill is needed |
| respModFault | output | 1 | Store to a slot that is not writable |
| respUncached | output | 1 | Access must bypass the data cache |
| wrEn | input | 1 | Load a slot |
| wrIndex | input | 6 | Slot to load |
| wrVpn | input | 20 | Virtual page number for the slot |
| wrAsid | input | 6 | Address-space tag for the slot |
| wrPpn | input | 20 | Physical frame number for the slot |
| wrWritable | input | 1 | Slot permits stores |
| wrValid | input | 1 | Slot is live |
| wrGlobal | input | 1 | Slot matches any address-space tag |
| wrNoCache | input | 1 | Accesses through the slot are uncached |
| invOne | input | 1 | Invalidate one slot |
| invIndex | input | 6 | Slot to invalidate |
| flushAll | input | 1 | Invalidate all slots |
| randIndex | output | 6 | Free-running slot suggestion for refill |

## Verification
The bench places the same page number under two different tags and under a global slot. A design that ignored the tag would hit where it must fault, and a design that ignored the global bit would fault where it must hit. It drives write and invalidate at the same slot in one cycle, and also at different slots in one cycle. Wrong priority would leave a live slot behind, and over-eager clearing would lose the unrelated write. Both bypass windows are checked for address truncation and the cache flag, and the kernel translated window is checked to make sure it is not bypassed. A store to a read-only slot must report the modify fault rather than a hit, and the index counter is followed across its wrap from 63 to 0.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PPN_W     = 20;
  localparam int PA_W      = PPN_W + PAGE_BITS;
  localparam int ASID_W    = 6;
  localparam int ENTRIES   = 64;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int SEG_W     = 3;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic              writable;
    logic              global;
    logic              noCache;
    logic              valid;
  } tlbEntry_t;

  typedef struct packed {
    logic             wrStrobe;
    logic [IDX_W-1:0] wrIdx;
    logic             invStrobe;
    logic [IDX_W-1:0] invIdx;
    logic             flushStrobe;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    SEG_MAPPED,
    SEG_PHYS_CACHED,
    SEG_PHYS_UNCACHED
  } segKind_t;
endpackage

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  tlbEntry_t         wrEntry,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              matchAny,
  output logic              matchWritable,
  output logic              matchNoCache,
  output logic [PPN_W-1:0]  matchPpn
);
  tlbEntry_t        slots [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] validVec;
  logic [IDX_W-1:0]   selIdx;

  // Storage: a later assignment overrides an earlier one, so flush beats
  // invalidate, and invalidate beats a write to the same slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ctrl.wrStrobe && ctrl.wrIdx == IDX_W'(i)) slots[i] <= wrEntry;
        if (ctrl.invStrobe && ctrl.invIdx == IDX_W'(i)) slots[i].valid <= 1'b0;
        if (ctrl.flushStrobe) slots[i].valid <= 1'b0;
      end
    end
  end

  // Parallel comparators, one per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign validVec[g] = slots[g].valid;
    assign matchVec[g] = slots[g].valid && (slots[g].vpn == lkVpn) &&
                         (slots[g].global || (slots[g].asid == lkAsid));
  end

  // Lowest matching slot wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign matchAny      = |matchVec;
  assign matchWritable = slots[selIdx].writable;
  assign matchNoCache  = slots[selIdx].noCache;
  assign matchPpn      = slots[selIdx].ppn;

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flushStrobe |=> (validVec == '0));

  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.invStrobe |=> !validVec[$past(ctrl.invIdx)]);

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrStrobe && !ctrl.flushStrobe &&
     !(ctrl.invStrobe && ctrl.invIdx == ctrl.wrIdx))
    |=> (validVec[$past(ctrl.wrIdx)] == $past(wrEntry.valid)));
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqStore,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic              invOne,
  input  logic [IDX_W-1:0]  invIndex,
  input  logic              flushAll,
  input  logic              matchAny,
  input  logic              matchWritable,
  input  logic              matchNoCache,
  input  logic [PPN_W-1:0]  matchPpn,
  output dpCtrl_t           ctrl,
  output logic [PA_W-1:0]   respPaddr,
  output logic              respHit,
  output logic              respFault,
  output logic              respModFault,
  output logic              respUncached,
  output logic [IDX_W-1:0]  randIndex
);
  segKind_t         segKind;
  logic [IDX_W-1:0] randCnt;

  always_comb begin
    unique case (reqVaddr[VA_W-1 -: SEG_W])
      3'b100:  segKind = SEG_PHYS_CACHED;
      3'b101:  segKind = SEG_PHYS_UNCACHED;
      default: segKind = SEG_MAPPED;
    endcase
  end

  always_comb begin
    ctrl.wrStrobe    = wrEn;
    ctrl.wrIdx       = wrIndex;
    ctrl.invStrobe   = invOne;
    ctrl.invIdx      = invIndex;
    ctrl.flushStrobe = flushAll;
  end

  always_comb begin
    respPaddr    = '0;
    respHit      = 1'b0;
    respFault    = 1'b0;
    respModFault = 1'b0;
    respUncached = 1'b0;
    if (reqValid) begin
      case (segKind)
        SEG_PHYS_CACHED, SEG_PHYS_UNCACHED: begin
          respPaddr    = {{SEG_W{1'b0}}, reqVaddr[VA_W-SEG_W-1:0]};
          respUncached = (segKind == SEG_PHYS_UNCACHED);
        end
        default: begin
          if (!matchAny) begin
            respFault = 1'b1;
          end else if (reqStore && !matchWritable) begin
            respModFault = 1'b1;
          end else begin
            respHit      = 1'b1;
            respPaddr    = {matchPpn, reqVaddr[PAGE_BITS-1:0]};
            respUncached = matchNoCache;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) randCnt <= '0;
    else       randCnt <= randCnt + 1'b1;
  end
  assign randIndex = randCnt;

  a_r5_outcome_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> (!respFault && !respModFault));

  a_r4_bypass_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVaddr[VA_W-1 -: 2] == 2'b10) |-> (!respHit && !respFault && !respModFault));

  a_r6_modfault_store: assert property (@(posedge clk) disable iff (!rstN)
    respModFault |-> reqStore);

  a_r10_rand_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (randIndex == IDX_W'($past(randIndex) + 1'b1)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!respHit && !respFault && !respModFault && respPaddr == '0));
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqStore,
  input  logic [ASID_W-1:0] curAsid,
  output logic [PA_W-1:0]   respPaddr,
  output logic              respHit,
  output logic              respFault,
  output logic              respModFault,
  output logic              respUncached,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic              wrWritable,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic              wrNoCache,
  input  logic              invOne,
  input  logic [IDX_W-1:0]  invIndex,
  input  logic              flushAll,
  output logic [IDX_W-1:0]  randIndex
);
  dpCtrl_t          ctrl;
  tlbEntry_t        wrEntry;
  logic             matchAny, matchWritable, matchNoCache;
  logic [PPN_W-1:0] matchPpn;

  always_comb begin
    wrEntry.vpn      = wrVpn;
    wrEntry.asid     = wrAsid;
    wrEntry.ppn      = wrPpn;
    wrEntry.writable = wrWritable;
    wrEntry.global   = wrGlobal;
    wrEntry.noCache  = wrNoCache;
    wrEntry.valid    = wrValid;
  end

  xlate_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqStore(reqStore), .wrEn(wrEn), .wrIndex(wrIndex), .invOne(invOne),
    .invIndex(invIndex), .flushAll(flushAll), .matchAny(matchAny),
    .matchWritable(matchWritable), .matchNoCache(matchNoCache),
    .matchPpn(matchPpn), .ctrl(ctrl), .respPaddr(respPaddr),
    .respHit(respHit), .respFault(respFault), .respModFault(respModFault),
    .respUncached(respUncached), .randIndex(randIndex)
  );

  xlate_dp i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrEntry(wrEntry),
    .lkVpn(reqVaddr[VA_W-1:PAGE_BITS]), .lkAsid(curAsid),
    .matchAny(matchAny), .matchWritable(matchWritable),
    .matchNoCache(matchNoCache), .matchPpn(matchPpn)
  );
endmodule

// File: tb/test_xlate_tlb.sv
module test_xlate_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqStore = 1'b0;
  logic [5:0]  curAsid = '0;
  logic [31:0] respPaddr;
  logic        respHit, respFault, respModFault, respUncached;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIndex = '0;
  logic [19:0] wrVpn = '0;
  logic [5:0]  wrAsid = '0;
  logic [19:0] wrPpn = '0;
  logic        wrWritable = 1'b0, wrValid = 1'b0, wrGlobal = 1'b0, wrNoCache = 1'b0;
  logic        invOne = 1'b0;
  logic [5:0]  invIndex = '0;
  logic        flushAll = 1'b0;
  logic [5:0]  randIndex;

  int nChecks = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  xlate_tlb i_xlate_tlb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqStore(reqStore), .curAsid(curAsid), .respPaddr(respPaddr),
    .respHit(respHit), .respFault(respFault), .respModFault(respModFault),
    .respUncached(respUncached), .wrEn(wrEn), .wrIndex(wrIndex),
    .wrVpn(wrVpn), .wrAsid(wrAsid), .wrPpn(wrPpn), .wrWritable(wrWritable),
    .wrValid(wrValid), .wrGlobal(wrGlobal), .wrNoCache(wrNoCache),
    .invOne(invOne), .invIndex(invIndex), .flushAll(flushAll),
    .randIndex(randIndex)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setWrite(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] as,
                          input logic [19:0] ppn, input logic wr, input logic v,
                          input logic gl, input logic nc);
    wrEn = 1'b1; wrIndex = idx; wrVpn = vpn; wrAsid = as; wrPpn = ppn;
    wrWritable = wr; wrValid = v; wrGlobal = gl; wrNoCache = nc;
  endtask

  task automatic writeSlot(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] as,
                           input logic [19:0] ppn, input logic wr, input logic v,
                           input logic gl, input logic nc);
    @(negedge clk);
    setWrite(idx, vpn, as, ppn, wr, v, gl, nc);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic st, input logic [5:0] as);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqStore = st; curAsid = as;
    #2;
  endtask

  task automatic tReset;
    #5;
    chk("R1 randIndex in reset", 32'(randIndex), 32'd0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    look(32'h0040_1000, 1'b0, 6'd0);
    chk("R1 empty user fault", 32'(respFault), 32'd1);
    look(32'hE000_1000, 1'b0, 6'd0);
    chk("R1 empty kernel-virtual fault", 32'(respFault), 32'd1);
  endtask

  task automatic tHit;
    writeSlot(6'd5, 20'h00400, 6'd3, 20'h12345, 1'b1, 1'b1, 1'b0, 1'b0);
    writeSlot(6'd63, 20'hE0001, 6'd3, 20'h0ABCD, 1'b1, 1'b1, 1'b0, 1'b1);
    look(32'h0040_0ABC, 1'b0, 6'd3);
    chk("R2 hit flag", 32'(respHit), 32'd1);
    chk("R2 paddr", respPaddr, 32'h1234_5ABC);
    chk("R2 cached", 32'(respUncached), 32'd0);
    look(32'hE000_1F00, 1'b0, 6'd3);
    chk("R5 11x translated hit", 32'(respHit), 32'd1);
    chk("R2 paddr 11x", respPaddr, 32'h0ABC_DF00);
    chk("R2 uncached from slot", 32'(respUncached), 32'd1);
    look(32'h0040_0ABC, 1'b1, 6'd3);
    chk("R6 store writable hits", 32'(respHit), 32'd1);
  endtask

  task automatic tAsid;
    look(32'h0040_0ABC, 1'b0, 6'd4);
    chk("R3 other tag fault", 32'(respFault), 32'd1);
    chk("R3 other tag no hit", 32'(respHit), 32'd0);
    chk("R5 miss paddr zero", respPaddr, 32'd0);
    writeSlot(6'd10, 20'h00777, 6'd0, 20'h00042, 1'b1, 1'b1, 1'b1, 1'b0);
    look(32'h0077_7010, 1'b0, 6'd9);
    chk("R3 global any tag", 32'(respHit), 32'd1);
    chk("R3 global paddr", respPaddr, 32'h0004_2010);
  endtask

  task automatic tSeg;
    look(32'h8000_1234, 1'b0, 6'd3);
    chk("R4 100 paddr", respPaddr, 32'h0000_1234);
    chk("R4 100 no hit", 32'(respHit), 32'd0);
    chk("R4 100 no fault", 32'(respFault), 32'd0);
    chk("R4 100 cached", 32'(respUncached), 32'd0);
    look(32'hBFFF_5678, 1'b1, 6'd3);
    chk("R4 101 paddr", respPaddr, 32'h1FFF_5678);
    chk("R4 101 uncached", 32'(respUncached), 32'd1);
    chk("R4 101 no mod fault", 32'(respModFault), 32'd0);
  endtask

  task automatic tModify;
    writeSlot(6'd7, 20'h00123, 6'd3, 20'h0BEEF, 1'b0, 1'b1, 1'b0, 1'b0);
    look(32'h0012_3004, 1'b0, 6'd3);
    chk("R6 load read-only hits", 32'(respHit), 32'd1);
    look(32'h0012_3004, 1'b1, 6'd3);
    chk("R6 store mod fault", 32'(respModFault), 32'd1);
    chk("R6 store no hit", 32'(respHit), 32'd0);
    chk("R6 store no miss fault", 32'(respFault), 32'd0);
  endtask

  task automatic tDeadSlot;
    writeSlot(6'd8, 20'h00555, 6'd3, 20'h00111, 1'b1, 1'b0, 1'b0, 1'b0);
    look(32'h0055_5000, 1'b0, 6'd3);
    chk("R5 dead slot fault", 32'(respFault), 32'd1);
  endtask

  task automatic tOverwrite;
    writeSlot(6'd12, 20'h00888, 6'd3, 20'h00AAA, 1'b1, 1'b1, 1'b0, 1'b0);
    writeSlot(6'd12, 20'h00888, 6'd3, 20'h00BBB, 1'b1, 1'b1, 1'b0, 1'b0);
    look(32'h0088_8020, 1'b0, 6'd3);
    chk("R7 overwrite paddr", respPaddr, 32'h00BB_B020);
  endtask

  task automatic tInvalidate;
    @(negedge clk);
    invOne = 1'b1; invIndex = 6'd5;
    @(negedge clk);
    invOne = 1'b0;
    look(32'h0040_0ABC, 1'b0, 6'd3);
    chk("R8 invalidated slot faults", 32'(respFault), 32'd1);
    @(negedge clk);
    setWrite(6'd11, 20'h00999, 6'd3, 20'h00CCC, 1'b1, 1'b1, 1'b0, 1'b0);
    invOne = 1'b1; invIndex = 6'd11;
    @(negedge clk);
    wrEn = 1'b0; invOne = 1'b0;
    look(32'h0099_9000, 1'b0, 6'd3);
    chk("R8 invalidate beats same-slot write", 32'(respFault), 32'd1);
    @(negedge clk);
    setWrite(6'd13, 20'h00321, 6'd3, 20'h00DDD, 1'b1, 1'b1, 1'b0, 1'b0);
    invOne = 1'b1; invIndex = 6'd7;
    @(negedge clk);
    wrEn = 1'b0; invOne = 1'b0;
    look(32'h0032_1008, 1'b0, 6'd3);
    chk("R8 other-slot write kept", respPaddr, 32'h00DD_D008);
    look(32'h0012_3004, 1'b0, 6'd3);
    chk("R8 other-slot invalidated", 32'(respFault), 32'd1);
  endtask

  task automatic tIdle;
    @(negedge clk);
    reqValid = 1'b0; reqVaddr = 32'h0032_1008; curAsid = 6'd3;
    #2;
    chk("R11 idle no hit", 32'(respHit), 32'd0);
    chk("R11 idle paddr zero", respPaddr, 32'd0);
  endtask

  task automatic tFlush;
    @(negedge clk);
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
    look(32'hE000_1F00, 1'b0, 6'd3);
    chk("R9 flush slot 63", 32'(respFault), 32'd1);
    look(32'h0077_7010, 1'b0, 6'd9);
    chk("R9 flush global", 32'(respFault), 32'd1);
    look(32'h0032_1008, 1'b0, 6'd3);
    chk("R9 flush slot 13", 32'(respFault), 32'd1);
  endtask

  task automatic tRand;
    logic [5:0] a;
    @(negedge clk); #2;
    a = randIndex;
    @(negedge clk); #2;
    chk("R10 step", 32'(randIndex), 32'(6'(a + 6'd1)));
    for (int k = 0; k < 70 && randIndex != 6'd63; k++) begin
      @(negedge clk); #2;
    end
    chk("R10 reached 63", 32'(randIndex), 32'd63);
    @(negedge clk); #2;
    chk("R10 wrap to 0", 32'(randIndex), 32'd0);
  endtask

  initial begin
    tReset();
    tHit();
    tAsid();
    tSeg();
    tModify();
    tDeadSlot();
    tOverwrite();
    tInvalidate();
    tIdle();
    tFlush();
    tRand();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule